// File: doc/BRIEF.md
# Region-Based Cache Write-Policy Controller

This block decides, store by store, how a data cache handles a write. The 32-bit physical address space is cut into 32 equal windows of 128 MB each. A 32-bit attribute word holds one bit per window. A clear bit gives write-back handling and a set bit gives write-through handling. For every data store the block takes the address and the cache hit/miss result. It returns three combinational action flags: update the cache line, write system memory, and allocate a new line.

Software sets the attribute word through a special-register port. Each access on that port carries a register number and a privilege flag. Only a privileged access to register number 954 (0x3BA) may read or write the word. Any other access is refused and flagged as a fault. Instruction-side requests never produce write actions, because the instruction cache is never written. The cache arrays, tag lookup, replacement and the bus side sit outside this block.

Top module: `wpc_policy_ctrl`

## Requirements
- R1: After reset the attribute word is all zeros. A legal read returns 0, and every region behaves as write-back.
- R2: The window of a store is k = st_addr[31:27]. Its policy bit is attribute-word bit (31-k), so written-data bit 31 governs 0x0000_0000..0x07FF_FFFF and bit 0 governs 0xF800_0000..0xFFFF_FFFF.
- R3: Policy bit 0 with a hit gives act_upd_line=1, act_wr_mem=0, act_alloc=0.
- R4: Policy bit 0 with a miss gives act_upd_line=1, act_alloc=1, act_wr_mem=0.
- R5: Policy bit 1 with a hit gives act_upd_line=1, act_wr_mem=1, act_alloc=0.
- R6: Policy bit 1 with a miss gives act_wr_mem=1, act_upd_line=0, act_alloc=0.
- R7: When st_valid is 0, or st_is_inst is 1, all three action flags are 0.
- R8: A legal write is one with reg_req=1, reg_we=1, reg_priv=1 and reg_num=954. It replaces the word at the next clock edge. A store presented in the following cycle already uses the new word. A legal read (reg_we=0) returns the stored word unchanged on reg_rdata in the same cycle.
- R9: A port access with reg_priv=0, or with reg_num other than 954, raises reg_fault and drives reg_rdata to 0 in that cycle. It leaves the attribute word unchanged.
- R10: reg_fault is 0 and reg_rdata is 0 whenever reg_req is 0. reg_fault is also 0 for legal accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_req | input | 1 | Special-register access valid |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_num | input | 10 | Register number of the access |
| reg_priv | input | 1 | Access comes from privileged mode |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, zero unless a legal read |
| reg_fault | output | 1 | Access refused (user mode or wrong number) |
| st_valid | input | 1 | A store is presented this cycle |
| st_is_inst | input | 1 | Request is from the instruction side |
| st_addr | input | 32 | Physical address of the store |
| st_hit | input | 1 | Cache lookup hit |
| act_upd_line | output | 1 | Write the data into the cache line |
| act_wr_mem | output | 1 | Write the data to system memory |
| act_alloc | output | 1 | Allocate a new cache line |

## Verification
The assertions assume that st_hit, st_addr and st_is_inst are known whenever st_valid is high. They also assume that the register-port inputs are known whenever reg_req is high. The stability check on read data also assumes that a write and a read never share a cycle, which the one-bit reg_we guarantees. The bench drives every input at the falling clock edge to a defined value, including the idle ones. Its random mix chooses register numbers either equal to 954 or drawn at random, with privilege drawn at random. As a result, refused accesses are interleaved with legal reads and writes, and with stores to random addresses.

// File: rtl/wpc_pkg.sv
// Package: shared sizes and the action type for the write-policy controller.
// Assumes a power-of-two region count that divides the address space evenly.
package wpc_pkg;
    parameter int unsigned ADDR_W       = 32;   // physical address width
    parameter int unsigned REGION_CNT   = 32;   // number of policy windows
    parameter int unsigned REGNUM_W     = 10;   // special-register number width
    parameter int unsigned ATTR_REG_NUM = 954;  // number of the attribute word

    // Action flags returned for each store.
    typedef struct packed {
        logic upd_line;
        logic wr_mem;
        logic alloc;
    } wpc_act_t;
endpackage

// File: rtl/wpc_attr_reg.sv
// Module: attribute word storage behind the special-register port.
// What it does: holds the per-region policy word. It accepts only privileged
// accesses to one register number, and flags every other access as a fault.
// Assumes: one access per cycle; read data and fault are combinational.
module wpc_attr_reg #(
    parameter int unsigned REG_W    = 32,
    parameter int unsigned NUM_W    = 10,
    parameter int unsigned MATCH_NUM = 954
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_req,
    input  logic             acc_we,
    input  logic [NUM_W-1:0] acc_num,
    input  logic             acc_priv,
    input  logic [REG_W-1:0] acc_wdata,
    output logic [REG_W-1:0] acc_rdata,
    output logic             acc_fault,
    output logic [REG_W-1:0] attr_q
);
    localparam logic [NUM_W-1:0] MATCH_V = NUM_W'(MATCH_NUM);

    logic acc_ok;
    logic wr_ok;
    logic rd_ok;

    // Classify the current access as legal or refused.
    always_comb begin
        acc_ok    = acc_req && acc_priv && (acc_num == MATCH_V);
        wr_ok     = acc_ok && acc_we;
        rd_ok     = acc_ok && !acc_we;
        acc_fault = acc_req && !acc_ok;
    end

    // Read mux: the stored word for a legal read, zero otherwise.
    always_comb begin
        acc_rdata = rd_ok ? attr_q : '0;
    end

    // Attribute word: cleared by reset, loaded by a legal write only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            attr_q <= '0;
        end else if (wr_ok) begin
            attr_q <= acc_wdata;
        end
    end
endmodule

// File: rtl/wpc_region_sel.sv
// Module: region policy lookup.
// What it does: picks the policy bit of the window that an address falls in.
// The attribute word is numbered MSB-first, so window k uses word bit
// (REGION_CNT-1-k).
// Assumes: only the top IDX_W address bits are passed in.
module wpc_region_sel #(
    parameter int unsigned REGION_CNT = 32,
    localparam int unsigned IDX_W     = $clog2(REGION_CNT)
) (
    input  logic [REGION_CNT-1:0] attr,
    input  logic [IDX_W-1:0]      region_idx,
    output logic                  wt_sel
);
    logic [REGION_CNT-1:0] by_region;

    // Reorder the word so that the vector index equals the window number.
    for (genvar k = 0; k < REGION_CNT; k++) begin : g_reorder
        assign by_region[k] = attr[REGION_CNT-1-k];
    end

    // Select the bit of the addressed window.
    always_comb begin
        wt_sel = by_region[region_idx];
    end
endmodule

// File: rtl/wpc_action_dec.sv
// Module: store action decoder.
// What it does: turns the policy bit and the hit/miss result into the three
// action flags. A write-through miss writes memory without allocating.
// Assumes: inputs are only meaningful while st_valid is high.
module wpc_action_dec
    import wpc_pkg::*;
(
    input  logic     st_valid,
    input  logic     st_is_inst,
    input  logic     st_hit,
    input  logic     wt_sel,
    output wpc_act_t act
);
    // Policy table, gated by a valid data-side store.
    always_comb begin
        act = '0;
        if (st_valid && !st_is_inst) begin
            unique case ({wt_sel, st_hit})
                2'b01: act = '{upd_line: 1'b1, wr_mem: 1'b0, alloc: 1'b0};
                2'b00: act = '{upd_line: 1'b1, wr_mem: 1'b0, alloc: 1'b1};
                2'b11: act = '{upd_line: 1'b1, wr_mem: 1'b1, alloc: 1'b0};
                default: act = '{upd_line: 1'b0, wr_mem: 1'b1, alloc: 1'b0};
            endcase
        end
    end
endmodule

// File: rtl/wpc_policy_ctrl.sv
// Module: top of the region-based cache write-policy controller.
// What it does: joins the attribute word, the region lookup and the action
// decoder. Actions are combinational, and a register write is visible from
// the next cycle on.
// Assumes: synchronous active-low reset; one store and one register access
// per cycle at most.
module wpc_policy_ctrl
    import wpc_pkg::*;
#(
    parameter int unsigned P_ADDR_W   = ADDR_W,
    parameter int unsigned P_REGIONS  = REGION_CNT,
    parameter int unsigned P_NUM_W    = REGNUM_W,
    parameter int unsigned P_REG_NUM  = ATTR_REG_NUM,
    localparam int unsigned IDX_W     = $clog2(P_REGIONS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_req,
    input  logic                 reg_we,
    input  logic [P_NUM_W-1:0]   reg_num,
    input  logic                 reg_priv,
    input  logic [P_REGIONS-1:0] reg_wdata,
    output logic [P_REGIONS-1:0] reg_rdata,
    output logic                 reg_fault,
    input  logic                 st_valid,
    input  logic                 st_is_inst,
    input  logic [P_ADDR_W-1:0]  st_addr,
    input  logic                 st_hit,
    output logic                 act_upd_line,
    output logic                 act_wr_mem,
    output logic                 act_alloc
);
    logic [P_REGIONS-1:0] attr_q;
    logic                 wt_sel;
    wpc_act_t             act;
    logic                 unused_low_addr;

    // Offset bits inside a window play no part in the policy.
    assign unused_low_addr = ^st_addr[P_ADDR_W-IDX_W-1:0];

    wpc_attr_reg #(
        .REG_W    (P_REGIONS),
        .NUM_W    (P_NUM_W),
        .MATCH_NUM(P_REG_NUM)
    ) u_attr (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_req  (reg_req),
        .acc_we   (reg_we),
        .acc_num  (reg_num),
        .acc_priv (reg_priv),
        .acc_wdata(reg_wdata),
        .acc_rdata(reg_rdata),
        .acc_fault(reg_fault),
        .attr_q   (attr_q)
    );

    wpc_region_sel #(
        .REGION_CNT(P_REGIONS)
    ) u_sel (
        .attr      (attr_q),
        .region_idx(st_addr[P_ADDR_W-1 -: IDX_W]),
        .wt_sel    (wt_sel)
    );

    wpc_action_dec u_dec (
        .st_valid  (st_valid),
        .st_is_inst(st_is_inst),
        .st_hit    (st_hit),
        .wt_sel    (wt_sel),
        .act       (act)
    );

    // Unpack the action flags to the ports.
    always_comb begin
        act_upd_line = act.upd_line;
        act_wr_mem   = act.wr_mem;
        act_alloc    = act.alloc;
    end
endmodule

// File: rtl/wpc_policy_chk.sv
// Module: property checker for wpc_policy_ctrl, attached through bind.
// Assumes: inputs are known while their valid signal is high.
module wpc_policy_chk #(
    parameter int unsigned P_REGIONS = 32,
    parameter int unsigned P_NUM_W   = 10,
    parameter int unsigned P_REG_NUM = 954
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 reg_req,
    input logic                 reg_we,
    input logic [P_NUM_W-1:0]   reg_num,
    input logic                 reg_priv,
    input logic [P_REGIONS-1:0] reg_rdata,
    input logic                 reg_fault,
    input logic                 st_valid,
    input logic                 st_is_inst,
    input logic                 st_hit,
    input logic                 act_upd_line,
    input logic                 act_wr_mem,
    input logic                 act_alloc
);
    logic legal;
    logic data_st;
    assign legal   = reg_req && reg_priv && (reg_num == P_NUM_W'(P_REG_NUM));
    assign data_st = st_valid && !st_is_inst;

    AST_IDLE_NO_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        !data_st |-> !(act_upd_line || act_wr_mem || act_alloc)); // R7
    AST_HIT_KEEPS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (data_st && st_hit) |-> (act_upd_line && !act_alloc)); // R3
    AST_ALLOC_IS_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
        act_alloc |-> (act_upd_line && !act_wr_mem)); // R4
    AST_MISS_ONE_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        (data_st && !st_hit) |-> (act_alloc != act_wr_mem)); // R6
    AST_REFUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && !legal) |-> (reg_fault && reg_rdata == '0)); // R9
    AST_IDLE_PORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_req |-> (!reg_fault && reg_rdata == '0)); // R10
    AST_RESET_WORD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!rst_n) && legal && !reg_we) |-> reg_rdata == '0); // R1
    AST_READ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(legal && !reg_we) && legal && !reg_we)
        |-> $stable(reg_rdata)); // R8
endmodule

bind wpc_policy_ctrl wpc_policy_chk #(
    .P_REGIONS(P_REGIONS),
    .P_NUM_W  (P_NUM_W),
    .P_REG_NUM(P_REG_NUM)
) u_chk (.*);

// File: tb/tb_wpc_policy_ctrl.sv
module tb_wpc_policy_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_req = 1'b0, reg_we = 1'b0, reg_priv = 1'b0;
    logic [9:0]  reg_num = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_fault;
    logic        st_valid = 1'b0, st_is_inst = 1'b0, st_hit = 1'b0;
    logic [31:0] st_addr = '0;
    logic        act_upd_line, act_wr_mem, act_alloc;

    int total = 0;
    int bad   = 0;
    logic [31:0] model_word = '0;

    always #2 clk = ~clk;  // 250 MHz

    wpc_policy_ctrl dut (.*);

    // Expected {upd, mem, alloc} from the requirements.
    function automatic logic [2:0] exp_act(logic [31:0] w, logic [31:0] a,
                                           logic h, logic v, logic inst);
        logic wt;
        if (!v || inst) return 3'b000;           // R7
        wt = w[31 - int'(a[31:27])];              // R2
        if (!wt) return h ? 3'b100 : 3'b101;     // R3 / R4
        return h ? 3'b110 : 3'b010;              // R5 / R6
    endfunction

    task automatic check(input logic ok, input string req,
                         input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic idle_inputs();
        reg_req = 0; reg_we = 0; reg_priv = 0; reg_num = '0; reg_wdata = '0;
        st_valid = 0; st_is_inst = 0; st_hit = 0; st_addr = '0;
    endtask

    // One register access: drive at negedge, check, commit at posedge.
    task automatic reg_access(input logic we, input logic [9:0] num,
                              input logic priv, input logic [31:0] wd);
        logic legal;
        @(negedge clk);
        idle_inputs();
        reg_req = 1; reg_we = we; reg_num = num; reg_priv = priv; reg_wdata = wd;
        legal = priv && (num == 10'd954);
        #1;
        check(reg_fault == !legal, legal ? "R10 fault" : "R9 fault",
              {31'd0, reg_fault}, {31'd0, !legal});
        check(reg_rdata == ((legal && !we) ? model_word : 32'd0),
              legal ? "R8 rdata" : "R9 rdata", reg_rdata,
              (legal && !we) ? model_word : 32'd0);
        if (legal && we) model_word = wd;
    endtask

    task automatic store(input logic [31:0] a, input logic h,
                         input logic v, input logic inst, input string req);
        logic [2:0] e;
        @(negedge clk);
        idle_inputs();
        st_valid = v; st_is_inst = inst; st_addr = a; st_hit = h;
        #1;
        e = exp_act(model_word, a, h, v, inst);
        check({act_upd_line, act_wr_mem, act_alloc} == e, req,
              {29'd0, act_upd_line, act_wr_mem, act_alloc}, {29'd0, e});
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: run did not complete, expected end before limit");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd12345));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        // Reset state (R1)
        reg_access(0, 10'd954, 1, '0);
        check(reg_rdata == 0, "R1 reset word", reg_rdata, 0);
        store(32'h0000_0000, 0, 1, 0, "R1 R4 reset miss allocates");
        store(32'hFFFF_FFFC, 1, 1, 0, "R1 R3 reset hit");
        // Region corners (R2)
        reg_access(1, 10'd954, 1, 32'h8000_0001);
        store(32'h07FF_FFFF, 1, 1, 0, "R2 R5 region0 hit");
        store(32'h0800_0000, 1, 1, 0, "R2 R3 region1 hit");
        store(32'hF800_0000, 0, 1, 0, "R2 R6 region31 miss");
        store(32'hF7FF_FFFF, 0, 1, 0, "R2 R4 region30 miss");
        reg_access(0, 10'd954, 1, '0);
        // Next-cycle effect (R8)
        reg_access(1, 10'd954, 1, 32'h0000_0000);
        store(32'h0000_0010, 0, 1, 0, "R8 next-cycle store sees new word");
        // Refused writes (R9)
        reg_access(1, 10'd954, 0, 32'hFFFF_FFFF);
        store(32'h1234_5678, 0, 1, 0, "R9 user write ignored");
        reg_access(1, 10'd953, 1, 32'hFFFF_FFFF);
        reg_access(0, 10'd954, 1, '0);
        check(reg_rdata == 0, "R9 wrong number write ignored", reg_rdata, 0);
        // Gating (R7)
        reg_access(1, 10'd954, 1, 32'hFFFF_FFFF);
        store(32'h4000_0000, 1, 1, 1, "R7 instruction side");
        store(32'h4000_0000, 0, 0, 0, "R7 store not valid");
        store(32'h4000_0000, 1, 1, 0, "R5 all write-through hit");
        store(32'h4000_0000, 0, 1, 0, "R6 all write-through miss");
        // Idle port (R10)
        @(negedge clk); idle_inputs(); #1;
        check(!reg_fault && reg_rdata == 0, "R10 idle port",
              {reg_fault, reg_rdata[30:0]}, 0);
        // Random mix
        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(0, 9) < 3) begin
                reg_access(1'($urandom_range(0, 1)),
                           ($urandom_range(0, 3) != 0) ? 10'd954 : 10'($urandom),
                           1'($urandom_range(0, 3) != 0), $urandom);
            end else begin
                store($urandom, 1'($urandom_range(0, 1)),
                      1'($urandom_range(0, 7) != 0), 1'($urandom_range(0, 7) == 0),
                      "R2 R3 R4 R5 R6 random store");
            end
        end
        // Reset clears a programmed word (R1)
        reg_access(1, 10'd954, 1, 32'hDEAD_BEEF);
        @(negedge clk); idle_inputs(); rst_n = 0;
        @(negedge clk); rst_n = 1; model_word = '0;
        reg_access(0, 10'd954, 1, '0);
        @(negedge clk); idle_inputs();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule